// File: doc/BRIEF.md
# Glitch-Free Clock Output Selector

This block picks the source that drives a video clock pin and a memory clock pin. The video source comes from two select pins and an external-clock select. A change on those pins is not applied at once. The pins also act as a serial programming port, so a new value is taken only after it has held steady for a full time-out. Until then the previous source keeps running.

Each time the video source is reselected, and each time the receiver reports that the active video register or the memory register has been rewritten, a settle interval follows. During that interval the affected output carries a fallback clock. For video, a control bit chooses the reference or the memory clock as fallback. For memory, the fallback is always the reference.

Power-down forces the video pin high and moves the memory pin to a slow refresh clock. Output enable low floats both pins. Every source change is made glitch-free: the switch waits for the old clock to be low, holds the output low, waits for the new clock to be low, and only then swaps sources. All candidate clocks are treated as signals sampled by a faster block clock, and the intervals are counted in cycles of that block clock.

Top module: `clk_sel_top`

## Requirements
- R1: With `oe` low, `vclk_oe` and `mclk_oe` are 0 and both clock outputs are driven 0, whatever the other inputs are.
- R2: With `oe` high and `pd_n` low, `vclk_o` is held at 1. Once the glitch-free switch has completed, `mclk_o` follows `pd_src`.
- R3: Select decoding uses {sel1, sel0} with sel1 as the upper bit: 00 selects `vid_src0`, 01 selects `vid_src1`, and 11 selects `vid_src2`.
- R4: {sel1, sel0} = 10 selects `ext_src` when `ext_sel` is 0 and `vid_src2` when `ext_sel` is 1.
- R5: A new {ext_sel, sel1, sel0} value is applied only after it has been stable for TO_CYC block-clock cycles. Any change within the window restarts it. Until then the output keeps the previous source, and pins that toggle faster than the window change nothing.
- R6: Each applied reselection starts a settle interval of SETTLE_CYC cycles. During it `vclk_o` carries the fallback clock, and afterwards the newly selected source.
- R7: `fb_mem` = 0 makes `ref_src` the video fallback. `fb_mem` = 1 makes `mem_src` the video fallback.
- R8: `long_to` = 1 doubles the select time-out to 2*TO_CYC cycles.
- R9: A `reprog_pulse` whose `reprog_idx` (0, 1, 2 = video registers) names the active video register starts a video settle interval. A pulse that names an inactive register leaves `vclk_o` on its source.
- R10: A `reprog_pulse` with `reprog_idx` = 3 (memory register) makes `mclk_o` carry `ref_src` for the settle interval and then return to `mem_src`.
- R11: A source swap happens only while the output is held low, and the hold is entered only from a low output. As a result, no high pulse on either clock output is shorter than half a period of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all intervals count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_src0 | input | 1 | Video candidate clock for register 0 |
| vid_src1 | input | 1 | Video candidate clock for register 1 |
| vid_src2 | input | 1 | Video candidate clock for register 2 |
| ext_src | input | 1 | External clock candidate |
| ref_src | input | 1 | Reference clock, used as fallback |
| mem_src | input | 1 | Memory clock from its synthesiser |
| pd_src | input | 1 | Slow refresh clock used in power-down |
| sel0 | input | 1 | Select pin, lower bit |
| sel1 | input | 1 | Select pin, upper bit |
| ext_sel | input | 1 | Replaces the external clock by register 2 on code 10 |
| oe | input | 1 | Output enable, low floats both outputs |
| pd_n | input | 1 | Active-low power-down |
| fb_mem | input | 1 | Video fallback choice: 0 reference, 1 memory clock |
| long_to | input | 1 | Doubles the select time-out |
| reprog_pulse | input | 1 | One-cycle notice that a register was rewritten |
| reprog_idx | input | 2 | Register rewritten: 0..2 video, 3 memory |
| vclk_o | output | 1 | Video clock output |
| vclk_oe | output | 1 | Video output driver enable |
| mclk_o | output | 1 | Memory clock output |
| mclk_oe | output | 1 | Memory output driver enable |

## Verification
The switch assertions assume that every candidate clock is much slower than the block clock and changes away from its sampling edge. Under that assumption, a low sample stays low until the swap edge. The bench builds each source from a counter that advances on the falling edge of the block clock, with half periods of four cycles or more. The select assertion assumes that the select pins reach the debounce only through the synchronizer. The bench drives those pins, `reprog_pulse` and the mode inputs only on falling edges, and holds each reprogram notice for exactly one cycle.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;

   typedef enum logic [1:0] {
      SW_IDLE    = 2'd0,
      SW_OLD_LOW = 2'd1,
      SW_NEW_LOW = 2'd2
   } sw_state_e;

   // video mux source slots
   localparam int VSRC_R0  = 0;
   localparam int VSRC_R1  = 1;
   localparam int VSRC_R2  = 2;
   localparam int VSRC_EXT = 3;
   localparam int VSRC_REF = 4;
   localparam int VSRC_MEM = 5;
   localparam int VSRC_N   = 6;
   localparam int VIW      = $clog2(VSRC_N);

   // memory mux source slots
   localparam int MSRC_MEM = 0;
   localparam int MSRC_REF = 1;
   localparam int MSRC_PD  = 2;
   localparam int MSRC_N   = 3;
   localparam int MIW      = $clog2(MSRC_N);

   localparam logic [1:0] REPROG_MEM_IDX = 2'd3;

   function automatic logic [VIW-1:0] vid_decode(input logic [1:0] pins, input logic ext_alt);
      logic [VIW-1:0] r;
      case (pins)
         2'b00:   r = VIW'(VSRC_R0);
         2'b01:   r = VIW'(VSRC_R1);
         2'b11:   r = VIW'(VSRC_R2);
         default: r = ext_alt ? VIW'(VSRC_R2) : VIW'(VSRC_EXT);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/clk_sel_sync.sv
module clk_sel_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/clk_sel_debounce.sv
module clk_sel_debounce #(
   parameter int W      = 3,
   parameter int TO_CYC = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         long_to,
   input  logic [W-1:0] d,
   output logic [W-1:0] applied,
   output logic         commit
);
   localparam int MAXC = 2 * TO_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [W-1:0]  d_q;
   logic [CW-1:0] cnt;
   logic [CW-1:0] lim_m1;

   assign lim_m1 = long_to ? CW'(MAXC - 1) : CW'(TO_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_q     <= '0;
         cnt     <= '0;
         applied <= '0;
         commit  <= 1'b0;
      end else begin
         d_q    <= d;
         commit <= 1'b0;
         if (d != d_q) begin
            cnt <= '0;
         end else if (d != applied) begin
            if (cnt >= lim_m1) begin
               applied <= d;
               commit  <= 1'b1;
               cnt     <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end
endmodule

// File: rtl/clk_sel_settle.sv
module clk_sel_settle #(
   parameter int SETTLE_CYC = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(SETTLE_CYC + 1);

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (start)      left <= CW'(SETTLE_CYC);
      else if (left != '0) left <= left - 1'b1;
   end

   assign active = (left != '0);
endmodule

// File: rtl/clk_sel_gfmux.sv
module clk_sel_gfmux
   import clk_sel_pkg::*;
#(
   parameter int N_SRC   = 6,
   parameter int IW      = $clog2(N_SRC),
   parameter int RST_IDX = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] src,
   input  logic [IW-1:0]    target,
   output logic [IW-1:0]    cur,
   output logic             hold,
   output logic             clk_o
);
   sw_state_e     state;
   logic [IW-1:0] nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SW_IDLE;
         cur   <= IW'(RST_IDX);
         nxt   <= IW'(RST_IDX);
         hold  <= 1'b0;
      end else begin
         case (state)
            SW_IDLE: begin
               if (target != cur) begin
                  nxt   <= target;
                  state <= SW_OLD_LOW;
               end
            end
            SW_OLD_LOW: begin
               if (!src[cur]) begin
                  hold  <= 1'b1;
                  state <= SW_NEW_LOW;
               end
            end
            SW_NEW_LOW: begin
               if (!src[nxt]) begin
                  cur   <= nxt;
                  hold  <= 1'b0;
                  state <= SW_IDLE;
               end
            end
            default: state <= SW_IDLE;
         endcase
      end
   end

   assign clk_o = src[cur] & ~hold;
endmodule

// File: rtl/clk_sel_top.sv
module clk_sel_top
   import clk_sel_pkg::*;
#(
   parameter int TO_CYC      = 64,
   parameter int SETTLE_CYC  = 128,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vid_src0,
   input  logic       vid_src1,
   input  logic       vid_src2,
   input  logic       ext_src,
   input  logic       ref_src,
   input  logic       mem_src,
   input  logic       pd_src,
   input  logic       sel0,
   input  logic       sel1,
   input  logic       ext_sel,
   input  logic       oe,
   input  logic       pd_n,
   input  logic       fb_mem,
   input  logic       long_to,
   input  logic       reprog_pulse,
   input  logic [1:0] reprog_idx,
   output logic       vclk_o,
   output logic       vclk_oe,
   output logic       mclk_o,
   output logic       mclk_oe
);
   localparam int SELW = 3;

   if (TO_CYC < 2) begin : g_bad_to
      $error("clk_sel_top: TO_CYC must be 2 or more");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("clk_sel_top: SETTLE_CYC must be 1 or more");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_sel_top: SYNC_STAGES must be 2 or more");
   end

   logic [SELW-1:0] sel_s;
   logic [SELW-1:0] applied;
   logic            commit;
   logic [VIW-1:0]  v_sel_idx;
   logic [VIW-1:0]  v_target;
   logic [MIW-1:0]  m_target;
   logic [VIW-1:0]  v_cur;
   logic [MIW-1:0]  m_cur;
   logic            v_hold, m_hold;
   logic            v_raw, m_raw;
   logic            v_settle_act, m_settle_act;
   logic            v_hit, m_hit;
   logic [VSRC_N-1:0] v_srcs;
   logic [MSRC_N-1:0] m_srcs;

   clk_sel_sync #(.W(SELW), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d({ext_sel, sel1, sel0}), .q(sel_s)
   );

   clk_sel_debounce #(.W(SELW), .TO_CYC(TO_CYC)) deb_i (
      .clk(clk), .rst_n(rst_n), .long_to(long_to), .d(sel_s),
      .applied(applied), .commit(commit)
   );

   assign v_sel_idx = vid_decode(applied[1:0], applied[2]);

   // a rewrite only matters for the register now in use
   assign v_hit = reprog_pulse && (reprog_idx != REPROG_MEM_IDX)
                  && (VIW'(reprog_idx) == v_sel_idx);
   assign m_hit = reprog_pulse && (reprog_idx == REPROG_MEM_IDX);

   clk_sel_settle #(.SETTLE_CYC(SETTLE_CYC)) vset_i (
      .clk(clk), .rst_n(rst_n), .start(commit | v_hit), .active(v_settle_act)
   );

   clk_sel_settle #(.SETTLE_CYC(SETTLE_CYC)) mset_i (
      .clk(clk), .rst_n(rst_n), .start(m_hit), .active(m_settle_act)
   );

   always_comb begin
      if (v_settle_act) v_target = fb_mem ? VIW'(VSRC_MEM) : VIW'(VSRC_REF);
      else              v_target = v_sel_idx;
   end

   always_comb begin
      if (!pd_n)             m_target = MIW'(MSRC_PD);
      else if (m_settle_act) m_target = MIW'(MSRC_REF);
      else                   m_target = MIW'(MSRC_MEM);
   end

   assign v_srcs = {mem_src, ref_src, ext_src, vid_src2, vid_src1, vid_src0};
   assign m_srcs = {pd_src, ref_src, mem_src};

   clk_sel_gfmux #(.N_SRC(VSRC_N), .IW(VIW), .RST_IDX(VSRC_R0)) vmux_i (
      .clk(clk), .rst_n(rst_n), .src(v_srcs), .target(v_target),
      .cur(v_cur), .hold(v_hold), .clk_o(v_raw)
   );

   clk_sel_gfmux #(.N_SRC(MSRC_N), .IW(MIW), .RST_IDX(MSRC_MEM)) mmux_i (
      .clk(clk), .rst_n(rst_n), .src(m_srcs), .target(m_target),
      .cur(m_cur), .hold(m_hold), .clk_o(m_raw)
   );

   always_comb begin
      vclk_oe = oe;
      mclk_oe = oe;
      if (!oe) begin
         vclk_o = 1'b0;
         mclk_o = 1'b0;
      end else begin
         vclk_o = pd_n ? v_raw : 1'b1;
         mclk_o = m_raw;
      end
   end
endmodule

// File: rtl/clk_sel_chk.sv
module clk_sel_chk #(
   parameter int TO_CYC = 64
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] sel_s,
   input logic [2:0] applied,
   input logic       long_to,
   input logic       commit,
   input logic       v_settle_act,
   input logic       m_settle_act,
   input logic       reprog_pulse,
   input logic [1:0] reprog_idx,
   input logic [2:0] v_cur,
   input logic       v_hold,
   input logic       v_raw,
   input logic [1:0] m_cur,
   input logic       m_hold
);
   localparam int MAXC = 2 * TO_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [2:0]    sel_prev;
   logic [CW-1:0] stable_cnt;
   logic [CW-1:0] need;

   assign need = long_to ? CW'(MAXC - 1) : CW'(TO_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_prev   <= '0;
         stable_cnt <= '0;
      end else begin
         sel_prev <= sel_s;
         if (sel_s != sel_prev)           stable_cnt <= '0;
         else if (stable_cnt != CW'(MAXC)) stable_cnt <= stable_cnt + 1'b1;
      end
   end

   AST_SEL_WAITED: assert property (@(posedge clk) disable iff (!rst_n)
      (applied != $past(applied)) |-> ($past(stable_cnt) >= $past(need))); // R5

   AST_COMMIT_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> v_settle_act); // R6

   AST_REPROG_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (reprog_pulse && reprog_idx == 2'd3) |=> m_settle_act); // R10

   AST_VSWAP_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (v_cur != $past(v_cur)) |-> $past(v_hold)); // R11

   AST_VHOLD_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v_hold) |-> !$past(v_raw)); // R11

   AST_MSWAP_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (m_cur != $past(m_cur)) |-> $past(m_hold)); // R11
endmodule

bind clk_sel_top clk_sel_chk #(.TO_CYC(TO_CYC)) chk_i (
   .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .applied(applied),
   .long_to(long_to), .commit(commit), .v_settle_act(v_settle_act),
   .m_settle_act(m_settle_act), .reprog_pulse(reprog_pulse),
   .reprog_idx(reprog_idx), .v_cur(v_cur), .v_hold(v_hold), .v_raw(v_raw),
   .m_cur(m_cur), .m_hold(m_hold)
);

// File: tb/clk_sel_top_tb.sv
module clk_sel_top_tb_top;
   localparam int TO  = 40;
   localparam int SET = 100;

   // bench source slots: 0..2 video regs, 3 ext, 4 ref, 5 mem, 6 pd, 7 const 1, 8 const 0
   localparam int S_R0 = 0, S_R1 = 1, S_R2 = 2, S_EXT = 3, S_REF = 4;
   localparam int S_MEM = 5, S_PD = 6, S_ONE = 7, S_ZERO = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel0 = 0, sel1 = 0, ext_sel = 0, oe = 1, pd_n = 1;
   logic fb_mem = 0, long_to = 0, reprog_pulse = 0;
   logic [1:0] reprog_idx = 2'd0;
   logic vclk_o, vclk_oe, mclk_o, mclk_oe;
   int unsigned tick = 0;
   logic [8:0] bs;
   int checks = 0, errs = 0;
   int runts = 0;
   bit done = 0;

   always #2 clk = ~clk;

   always @(negedge clk) tick <= tick + 1;

   function automatic logic half(input int unsigned t, input int p);
      return (t % p) < (p / 2);
   endfunction

   always_comb begin
      bs[0] = half(tick, 8);
      bs[1] = half(tick, 10);
      bs[2] = half(tick, 12);
      bs[3] = half(tick, 14);
      bs[4] = half(tick, 18);
      bs[5] = half(tick, 22);
      bs[6] = half(tick, 26);
      bs[7] = 1'b1;
      bs[8] = 1'b0;
   end

   clk_sel_top #(.TO_CYC(TO), .SETTLE_CYC(SET), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .vid_src0(bs[0]), .vid_src1(bs[1]), .vid_src2(bs[2]), .ext_src(bs[3]),
      .ref_src(bs[4]), .mem_src(bs[5]), .pd_src(bs[6]),
      .sel0(sel0), .sel1(sel1), .ext_sel(ext_sel), .oe(oe), .pd_n(pd_n),
      .fb_mem(fb_mem), .long_to(long_to), .reprog_pulse(reprog_pulse),
      .reprog_idx(reprog_idx), .vclk_o(vclk_o), .vclk_oe(vclk_oe),
      .mclk_o(mclk_o), .mclk_oe(mclk_oe)
   );

   // high-pulse width monitor for R11
   int vrun = 0, mrun = 0;
   bit vval = 0, mval = 0;
   logic vlast = 0, mlast = 0;
   always @(posedge clk) begin
      #1;
      if (!(rst_n && oe && pd_n)) begin
         vval = 0; mval = 0; vrun = 0; mrun = 0;
      end else begin
         if (vclk_o != vlast) begin
            if (vval && vlast && vrun < 4) runts++;
            vval = 1; vrun = 1;
         end else vrun++;
         if (mclk_o != mlast) begin
            if (mval && mlast && mrun < 4) runts++;
            mval = 1; mrun = 1;
         end else mrun++;
      end
      vlast = vclk_o;
      mlast = mclk_o;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic follow(input bit on_m, input int idx, input int n, input string tag);
      int mis = 0;
      repeat (n) begin
         @(posedge clk); #1;
         if ((on_m ? mclk_o : vclk_o) !== bs[idx]) mis++;
      end
      chk(mis == 0, tag, mis, 0);
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic set_sel(input logic s1, input logic s0, input logic es);
      @(negedge clk);
      sel1 = s1; sel0 = s0; ext_sel = es;
   endtask

   task automatic pulse_reprog(input logic [1:0] idx);
      @(negedge clk);
      reprog_idx = idx; reprog_pulse = 1;
      @(negedge clk);
      reprog_pulse = 0;
   endtask

   task automatic t_reset;
      wait_cyc(5); #1;
      chk(vclk_oe === 1'b1 && mclk_oe === 1'b1, "R1 enables high after reset", vclk_oe, 1);
      follow(0, S_R0, 40, "R3 code 00 gives register 0 after reset");
      follow(1, S_MEM, 40, "R10 memory output on memory clock after reset");
   endtask

   task automatic t_sel_reg1;
      set_sel(0, 1, 0);
      follow(0, S_R0, 30, "R5 old source kept inside time-out");
      wait_cyc(50);
      follow(0, S_REF, 40, "R6 R7 reference fallback while settling");
      wait_cyc(60);
      follow(0, S_R1, 40, "R3 code 01 gives register 1");
   endtask

   task automatic t_sel_reg2_memfb;
      @(negedge clk); fb_mem = 1;
      set_sel(1, 1, 0);
      follow(0, S_R1, 30, "R5 old source kept inside time-out");
      wait_cyc(50);
      follow(0, S_MEM, 40, "R7 memory clock fallback while settling");
      wait_cyc(60);
      follow(0, S_R2, 40, "R3 code 11 gives register 2");
      @(negedge clk); fb_mem = 0;
   endtask

   task automatic t_ext;
      set_sel(1, 0, 0);
      wait_cyc(180);
      follow(0, S_EXT, 40, "R4 code 10 with ext_sel 0 gives external clock");
      set_sel(1, 0, 1);
      wait_cyc(180);
      follow(0, S_R2, 40, "R4 code 10 with ext_sel 1 gives register 2");
   endtask

   task automatic t_toggle;
      for (int i = 0; i < 10; i++) begin
         set_sel((i % 2) == 0 ? 1'b0 : 1'b1, 0, 1);
         follow(0, S_R2, 19, "R5 fast pin toggling ignored");
      end
      follow(0, S_R2, 200, "R5 no late switch after toggling");
   endtask

   task automatic t_long;
      @(negedge clk); long_to = 1;
      set_sel(0, 1, 0);
      follow(0, S_R2, 70, "R8 doubled time-out keeps old source");
      wait_cyc(50);
      follow(0, S_REF, 40, "R8 fallback after doubled time-out");
      wait_cyc(60);
      follow(0, S_R1, 40, "R8 new source after doubled time-out");
      @(negedge clk); long_to = 0;
   endtask

   task automatic t_reprog;
      pulse_reprog(2'd1);
      wait_cyc(40);
      follow(0, S_REF, 50, "R9 active register rewrite gives fallback");
      wait_cyc(50);
      follow(0, S_R1, 40, "R9 active register back after settle");
      pulse_reprog(2'd0);
      follow(0, S_R1, 120, "R9 inactive register rewrite ignored");
      pulse_reprog(2'd3);
      wait_cyc(40);
      follow(1, S_REF, 50, "R10 memory rewrite gives reference");
      wait_cyc(50);
      follow(1, S_MEM, 40, "R10 memory clock back after settle");
   endtask

   task automatic t_pd;
      @(negedge clk); pd_n = 0;
      follow(0, S_ONE, 30, "R2 video forced high in power-down");
      wait_cyc(10);
      follow(1, S_PD, 40, "R2 memory output on refresh clock");
      @(negedge clk); pd_n = 1;
      wait_cyc(60);
      follow(0, S_R1, 40, "R2 video resumes after power-down");
      follow(1, S_MEM, 40, "R2 memory clock resumes after power-down");
   endtask

   task automatic t_oe;
      @(negedge clk); oe = 0;
      @(posedge clk); #1;
      chk(vclk_oe === 1'b0, "R1 video enable low", vclk_oe, 0);
      chk(mclk_oe === 1'b0, "R1 memory enable low", mclk_oe, 0);
      follow(0, S_ZERO, 20, "R1 video output driven 0");
      follow(1, S_ZERO, 20, "R1 memory output driven 0");
      @(negedge clk); oe = 1;
      wait_cyc(40);
   endtask

   initial begin
      wait_cyc(5);
      @(negedge clk); rst_n = 1;
      t_reset;
      t_sel_reg1;
      t_sel_reg2_memfb;
      t_ext;
      t_toggle;
      t_long;
      t_reprog;
      t_pd;
      t_oe;
      chk(runts == 0, "R11 no short high pulse on any switch", runts, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog R5 run did not complete actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule